// File: doc/BRIEF.md
# Tag-Wakeup Reservation Station

This block holds renamed instructions in front of a single functional unit until their operands exist. Each decoded instruction names a destination register and two source registers. A register alias table supplies, for every source, either its value or the tag of the instruction that will produce it. The instruction is then parked in a free waiting slot, and the number of that slot becomes its result tag. The alias table entry of the destination is pointed at that tag.

All waiting slots and the alias table watch one result bus, which carries a tag and a value and is driven by an external bus arbiter. A slot whose pending tag matches the bus copies the value. The alias table also copies the value, but only into entries whose recorded latest writer carries that tag. Slots with both operands present compete for the unit. The oldest one, by insertion order, is sent each cycle. A sent slot keeps its tag reserved until the result for that tag appears on the bus. The slot and its tag are then released together.

Top module: `twu_station`

## Requirements
- R1: After reset all slots are free, every alias entry is valid and register r holds the value r, `dec_ready` is 1, `dec_tag` is 0 and `iss_valid` is 0.
- R2: A decode request is taken at a clock edge only when `dec_valid` and `dec_ready` are both 1. `dec_ready` is 0 while every slot is occupied, counting slots that were sent and still await their broadcast. A request made while `dec_ready` is 0 changes neither the slots nor the alias table.
- R3: A taken instruction gets the lowest-numbered free slot, and that slot number, shown on `dec_tag` before the edge, is its tag. Each source whose alias entry is valid is stored as that entry's value. The destination entry then becomes invalid with the new tag.
- R4: A waiting slot whose source is pending on tag T takes the bus value at the edge where the bus is valid with tag T, and that source becomes ready.
- R5: If a source's producer tag is on the bus in the same cycle that the instruction is inserted, the source is stored ready with the bus value.
- R6: A slot is sent only when both sources are ready. It appears on `iss_*` in the cycle after the edge at which its last source became ready, or after its insertion if both sources were ready then.
- R7: At most one slot is sent per cycle. Among the ready slots, the one inserted earliest is chosen, whatever its slot number.
- R8: A broadcast writes an alias entry and marks it valid only when the entry's tag equals the bus tag. A result from an older writer of the same register leaves the entry pending on the newer tag.
- R9: The bus may only carry the tag of a slot that was sent and not yet released. That broadcast frees the slot, and its number can be handed out again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_op | input | OP_W | Operation code carried to the unit |
| dec_dst | input | log2(NUM_REGS) | Destination register |
| dec_src_a | input | log2(NUM_REGS) | First source register |
| dec_src_b | input | log2(NUM_REGS) | Second source register |
| dec_ready | output | 1 | A free slot exists; decode may proceed |
| dec_tag | output | log2(NUM_SLOTS) | Tag the offered instruction will receive |
| bc_valid | input | 1 | Result bus carries a result this cycle |
| bc_tag | input | log2(NUM_SLOTS) | Tag of the broadcast result |
| bc_data | input | DATA_W | Value of the broadcast result |
| iss_valid | output | 1 | An instruction is sent to the unit this cycle |
| iss_tag | output | log2(NUM_SLOTS) | Tag of the sent instruction |
| iss_op | output | OP_W | Operation code of the sent instruction |
| iss_opnd_a | output | DATA_W | First operand value |
| iss_opnd_b | output | DATA_W | Second operand value |

## Verification
The bench makes a consumer wait on a producer and checks that it is held back until the broadcast, then sent with the broadcast value. A design with broken wakeup would send a stale operand or stall forever. It broadcasts the producer's tag in the very cycle the consumer is inserted, which a design without the insert bypass would lose, leaving the consumer hung. It writes one register twice and broadcasts the older writer first, so an alias table that ignores its tag would hand a later reader the stale value at once. It also fills every slot so that a younger instruction sits in a lower slot number than an older one, which exposes a selector that picks by position. A request made while the station is full must leave no trace in the alias table, or a later reader of that register would never be sent.

// File: rtl/twu_pkg.sv
package twu_pkg;

    // Life cycle of a waiting slot. FREE must encode as zero: reset clears the pool to zeros.
    typedef enum logic [1:0] {
        SLOT_FREE = 2'b00,
        SLOT_WAIT = 2'b01,
        SLOT_EXEC = 2'b10
    } slot_state_e;

endpackage

// File: rtl/twu_alias_table.sv
module twu_alias_table #(
    parameter int NUM_REGS = 8,
    parameter int TAG_W    = 2,
    parameter int DATA_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_REGS)-1:0] rd_a_idx,
    input  logic [$clog2(NUM_REGS)-1:0] rd_b_idx,
    output logic                        rd_a_vld,
    output logic [TAG_W-1:0]            rd_a_tag,
    output logic [DATA_W-1:0]           rd_a_data,
    output logic                        rd_b_vld,
    output logic [TAG_W-1:0]            rd_b_tag,
    output logic [DATA_W-1:0]           rd_b_data,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        bc_valid,
    input  logic [TAG_W-1:0]            bc_tag,
    input  logic [DATA_W-1:0]           bc_data
);

    localparam int REG_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } rat_ent_t;

    typedef struct packed {
        rat_ent_t [NUM_REGS-1:0] ent;
    } rat_state_t;

    rat_state_t st_d, st_q;

    function automatic rat_state_t reset_image();
        rat_state_t img;
        for (int r = 0; r < NUM_REGS; r++) begin
            img.ent[r].vld  = 1'b1;
            img.ent[r].tag  = '0;
            img.ent[r].data = DATA_W'(r);
        end
        return img;
    endfunction

    // Reads see the registered table; the slot pool bypasses a same-cycle broadcast itself.
    assign rd_a_vld  = st_q.ent[rd_a_idx].vld;
    assign rd_a_tag  = st_q.ent[rd_a_idx].tag;
    assign rd_a_data = st_q.ent[rd_a_idx].data;
    assign rd_b_vld  = st_q.ent[rd_b_idx].vld;
    assign rd_b_tag  = st_q.ent[rd_b_idx].tag;
    assign rd_b_data = st_q.ent[rd_b_idx].data;

    always_comb begin
        st_d = st_q;
        // Snoop: only the newest writer's tag turns a pending entry valid.
        for (int r = 0; r < NUM_REGS; r++) begin
            if (bc_valid && !st_q.ent[r].vld && st_q.ent[r].tag == bc_tag) begin
                st_d.ent[r].vld  = 1'b1;
                st_d.ent[r].data = bc_data;
            end
        end
        // A rename in the same cycle is newer than any result on the bus.
        if (wr_en) begin
            st_d.ent[wr_idx].vld = 1'b0;
            st_d.ent[wr_idx].tag = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_image();
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_rat_chk
        AST_RAT_TAKES_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && !st_q.ent[k].vld && st_q.ent[k].tag == bc_tag && !(wr_en && wr_idx == REG_W'(k)))
            |=> (st_q.ent[k].vld && st_q.ent[k].data == $past(bc_data))); // R8
        AST_RAT_STALE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_q.ent[k].vld && !(bc_valid && st_q.ent[k].tag == bc_tag) && !(wr_en && wr_idx == REG_W'(k)))
            |=> (!st_q.ent[k].vld && $stable(st_q.ent[k].tag))); // R8
    end

endmodule

// File: rtl/twu_oldest_pick.sv
module twu_oldest_pick #(
    parameter int NUM_SLOTS = 4,
    parameter int AGE_W     = 2
) (
    input  logic [NUM_SLOTS-1:0]         req,
    input  logic [NUM_SLOTS*AGE_W-1:0]   ages,
    output logic                         any,
    output logic [$clog2(NUM_SLOTS)-1:0] idx
);

    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic [AGE_W-1:0] best;

    // Larger age means inserted earlier; strict compare keeps the lower index on a tie.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (req[s] && (!any || ages[s*AGE_W +: AGE_W] > best)) begin
                any  = 1'b1;
                idx  = IDX_W'(s);
                best = ages[s*AGE_W +: AGE_W];
            end
        end
    end

endmodule

// File: rtl/twu_slot_pool.sv
module twu_slot_pool
    import twu_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int TAG_W     = 2,
    parameter int DATA_W    = 16,
    parameter int OP_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_fire,
    input  logic [OP_W-1:0]   ins_op,
    input  logic              ins_a_rdy,
    input  logic [TAG_W-1:0]  ins_a_tag,
    input  logic [DATA_W-1:0] ins_a_data,
    input  logic              ins_b_rdy,
    input  logic [TAG_W-1:0]  ins_b_tag,
    input  logic [DATA_W-1:0] ins_b_data,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              free_any,
    output logic [TAG_W-1:0]  free_idx,
    output logic              iss_valid,
    output logic [TAG_W-1:0]  iss_idx,
    output logic [OP_W-1:0]   iss_op,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b
);

    typedef struct packed {
        slot_state_e       st;
        logic [OP_W-1:0]   op;
        logic              rdy_a;
        logic              rdy_b;
        logic [TAG_W-1:0]  tag_a;
        logic [TAG_W-1:0]  tag_b;
        logic [DATA_W-1:0] val_a;
        logic [DATA_W-1:0] val_b;
        logic [TAG_W-1:0]  age;   // number of live slots inserted after this one
    } slot_t;

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] s;
    } pool_state_t;

    pool_state_t st_d, st_q;

    logic [NUM_SLOTS-1:0]       elig;
    logic [NUM_SLOTS-1:0]       rel_hit;
    logic [NUM_SLOTS*TAG_W-1:0] age_flat;
    logic                       rel_any;
    logic [TAG_W-1:0]           rel_age;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign elig[g]    = (st_q.s[g].st == SLOT_WAIT) && st_q.s[g].rdy_a && st_q.s[g].rdy_b;
        assign rel_hit[g] = bc_valid && (bc_tag == TAG_W'(g)) && (st_q.s[g].st == SLOT_EXEC);
        assign age_flat[g*TAG_W +: TAG_W] = st_q.s[g].age;
    end

    assign rel_any = |rel_hit;
    assign rel_age = st_q.s[bc_tag].age;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (st_q.s[s].st == SLOT_FREE) begin
                free_any = 1'b1;
                free_idx = TAG_W'(s);
            end
        end
    end

    twu_oldest_pick #(
        .NUM_SLOTS (NUM_SLOTS),
        .AGE_W     (TAG_W)
    ) u_pick (
        .req  (elig),
        .ages (age_flat),
        .any  (iss_valid),
        .idx  (iss_idx)
    );

    assign iss_op = st_q.s[iss_idx].op;
    assign iss_a  = st_q.s[iss_idx].val_a;
    assign iss_b  = st_q.s[iss_idx].val_b;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (st_q.s[s].st != SLOT_FREE) begin
                st_d.s[s].age = st_q.s[s].age + TAG_W'(ins_fire)
                              - TAG_W'(rel_any && (rel_age < st_q.s[s].age));
            end
            if (st_q.s[s].st == SLOT_WAIT) begin
                if (!st_q.s[s].rdy_a && bc_valid && st_q.s[s].tag_a == bc_tag) begin
                    st_d.s[s].rdy_a = 1'b1;
                    st_d.s[s].val_a = bc_data;
                end
                if (!st_q.s[s].rdy_b && bc_valid && st_q.s[s].tag_b == bc_tag) begin
                    st_d.s[s].rdy_b = 1'b1;
                    st_d.s[s].val_b = bc_data;
                end
            end
            if (rel_hit[s]) st_d.s[s].st = SLOT_FREE;
        end
        if (iss_valid) st_d.s[iss_idx].st = SLOT_EXEC;
        if (ins_fire) begin
            st_d.s[free_idx].st    = SLOT_WAIT;
            st_d.s[free_idx].op    = ins_op;
            st_d.s[free_idx].age   = '0;
            st_d.s[free_idx].tag_a = ins_a_tag;
            st_d.s[free_idx].tag_b = ins_b_tag;
            if (ins_a_rdy) begin
                st_d.s[free_idx].rdy_a = 1'b1;
                st_d.s[free_idx].val_a = ins_a_data;
            end else if (bc_valid && ins_a_tag == bc_tag) begin
                st_d.s[free_idx].rdy_a = 1'b1;
                st_d.s[free_idx].val_a = bc_data;
            end else begin
                st_d.s[free_idx].rdy_a = 1'b0;
                st_d.s[free_idx].val_a = '0;
            end
            if (ins_b_rdy) begin
                st_d.s[free_idx].rdy_b = 1'b1;
                st_d.s[free_idx].val_b = ins_b_data;
            end else if (bc_valid && ins_b_tag == bc_tag) begin
                st_d.s[free_idx].rdy_b = 1'b1;
                st_d.s[free_idx].val_b = bc_data;
            end else begin
                st_d.s[free_idx].rdy_b = 1'b0;
                st_d.s[free_idx].val_b = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_INSERT_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_fire |-> (free_any && st_q.s[free_idx].st == SLOT_FREE)); // R2
    AST_BCAST_HITS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> (st_q.s[bc_tag].st == SLOT_EXEC)); // R9
    AST_SEND_BOTH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (st_q.s[iss_idx].st == SLOT_WAIT && st_q.s[iss_idx].rdy_a && st_q.s[iss_idx].rdy_b)); // R6
    AST_HELD_UNTIL_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> (st_q.s[$past(iss_idx)].st == SLOT_EXEC)); // R9

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
        AST_WAKE_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.s[g].st == SLOT_WAIT && !st_q.s[g].rdy_a && bc_valid && st_q.s[g].tag_a == bc_tag)
            |=> (st_q.s[g].rdy_a && st_q.s[g].val_a == $past(bc_data))); // R4
        AST_WAKE_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.s[g].st == SLOT_WAIT && !st_q.s[g].rdy_b && bc_valid && st_q.s[g].tag_b == bc_tag)
            |=> (st_q.s[g].rdy_b && st_q.s[g].val_b == $past(bc_data))); // R4
        AST_PICK_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && elig[g]) |-> (st_q.s[g].age <= st_q.s[iss_idx].age)); // R7
    end

endmodule

// File: rtl/twu_station.sv
module twu_station #(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 16,
    parameter int OP_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         dec_valid,
    input  logic [OP_W-1:0]              dec_op,
    input  logic [$clog2(NUM_REGS)-1:0]  dec_dst,
    input  logic [$clog2(NUM_REGS)-1:0]  dec_src_a,
    input  logic [$clog2(NUM_REGS)-1:0]  dec_src_b,
    output logic                         dec_ready,
    output logic [$clog2(NUM_SLOTS)-1:0] dec_tag,
    input  logic                         bc_valid,
    input  logic [$clog2(NUM_SLOTS)-1:0] bc_tag,
    input  logic [DATA_W-1:0]            bc_data,
    output logic                         iss_valid,
    output logic [$clog2(NUM_SLOTS)-1:0] iss_tag,
    output logic [OP_W-1:0]              iss_op,
    output logic [DATA_W-1:0]            iss_opnd_a,
    output logic [DATA_W-1:0]            iss_opnd_b
);

    localparam int TAG_W = $clog2(NUM_SLOTS);

    logic              ins_fire;
    logic              free_any;
    logic [TAG_W-1:0]  free_idx;
    logic              a_vld, b_vld;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;

    assign dec_ready = free_any;
    assign dec_tag   = free_idx;
    assign ins_fire  = dec_valid && free_any;

    twu_alias_table #(
        .NUM_REGS (NUM_REGS),
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W)
    ) u_rat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (dec_src_a),
        .rd_b_idx  (dec_src_b),
        .rd_a_vld  (a_vld),
        .rd_a_tag  (a_tag),
        .rd_a_data (a_data),
        .rd_b_vld  (b_vld),
        .rd_b_tag  (b_tag),
        .rd_b_data (b_data),
        .wr_en     (ins_fire),
        .wr_idx    (dec_dst),
        .wr_tag    (free_idx),
        .bc_valid  (bc_valid),
        .bc_tag    (bc_tag),
        .bc_data   (bc_data)
    );

    twu_slot_pool #(
        .NUM_SLOTS (NUM_SLOTS),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W),
        .OP_W      (OP_W)
    ) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_fire   (ins_fire),
        .ins_op     (dec_op),
        .ins_a_rdy  (a_vld),
        .ins_a_tag  (a_tag),
        .ins_a_data (a_data),
        .ins_b_rdy  (b_vld),
        .ins_b_tag  (b_tag),
        .ins_b_data (b_data),
        .bc_valid   (bc_valid),
        .bc_tag     (bc_tag),
        .bc_data    (bc_data),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .iss_valid  (iss_valid),
        .iss_idx    (iss_tag),
        .iss_op     (iss_op),
        .iss_a      (iss_opnd_a),
        .iss_b      (iss_opnd_b)
    );

    AST_FULL_BLOCKS_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |-> !ins_fire); // R2

endmodule

// File: tb/twu_station_test.sv
`timescale 1ns/1ps
module twu_station_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [3:0]  dec_op = '0;
    logic [2:0]  dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic        dec_ready;
    logic [1:0]  dec_tag;
    logic        bc_valid = 1'b0;
    logic [1:0]  bc_tag = '0;
    logic [15:0] bc_data = '0;
    logic        iss_valid;
    logic [1:0]  iss_tag;
    logic [3:0]  iss_op;
    logic [15:0] iss_opnd_a, iss_opnd_b;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0]  tag;
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    twu_station uut (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_op(dec_op), .dec_dst(dec_dst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .dec_ready(dec_ready), .dec_tag(dec_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
        .iss_opnd_a(iss_opnd_a), .iss_opnd_b(iss_opnd_b)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: every sent instruction must be the next expected one (order is R7).
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "unexpected send, tag", int'(iss_tag), -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(iss_tag == e.tag, "R7", "sent tag", int'(iss_tag), int'(e.tag));
                check(iss_op == e.op, "R7", "sent op", int'(iss_op), int'(e.op));
                check(iss_opnd_a == e.a, "R7", "operand a", int'(iss_opnd_a), int'(e.a));
                check(iss_opnd_b == e.b, "R7", "operand b", int'(iss_opnd_b), int'(e.b));
            end
        end
    end

    // Driver: called at a falling edge, insert takes effect at the next rising edge.
    task automatic ins(input logic [3:0] op, input logic [2:0] dst, input logic [2:0] sa,
                       input logic [2:0] sb, input bit expect_now, input logic [15:0] ea,
                       input logic [15:0] eb, input bit with_bc, input logic [1:0] btag,
                       input logic [15:0] bdata, output logic [1:0] tag);
        tag = dec_tag;
        if (expect_now) sb_q.push_back('{tag: dec_tag, op: op, a: ea, b: eb});
        dec_valid = 1'b1; dec_op = op; dec_dst = dst; dec_src_a = sa; dec_src_b = sb;
        bc_valid = with_bc; bc_tag = btag; bc_data = bdata;
        @(negedge clk);
        dec_valid = 1'b0; bc_valid = 1'b0;
    endtask

    task automatic bcast(input logic [1:0] tag, input logic [15:0] data);
        bc_valid = 1'b1; bc_tag = tag; bc_data = data;
        @(negedge clk);
        bc_valid = 1'b0;
    endtask

    task automatic expect_send(input logic [1:0] tag, input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        sb_q.push_back('{tag: tag, op: op, a: a, b: b});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "R6", "watchdog expired, cycles", 5000, 0);
        summary();
        $finish;
    end

    initial begin
        logic [1:0] t0, t1, ta, tb, tc, td, te, tf, tp, tq, tx, ty, tz, tr, tdum;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(dec_ready == 1'b1, "R1", "dec_ready in reset", int'(dec_ready), 1);
        check(dec_tag == 2'd0, "R1", "dec_tag in reset", int'(dec_tag), 0);
        check(iss_valid == 1'b0, "R1", "iss_valid in reset", int'(iss_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: both sources valid, values are register numbers after reset
        ins(4'd1, 3'd1, 3'd2, 3'd3, 1'b1, 16'd2, 16'd3, 1'b0, 2'd0, 16'd0, t0);
        check(t0 == 2'd0, "R3", "first tag", int'(t0), 0);
        check(iss_valid && iss_opnd_a == 16'd2 && iss_opnd_b == 16'd3, "R3", "operand a from alias table", int'(iss_opnd_a), 2);
        @(negedge clk);
        bcast(t0, 16'd100);
        check(dec_tag == 2'd0, "R9", "released tag reused", int'(dec_tag), 0);
        ins(4'd2, 3'd4, 3'd1, 3'd1, 1'b1, 16'd100, 16'd100, 1'b0, 2'd0, 16'd0, t1);
        @(negedge clk);
        bcast(t1, 16'd200);

        // R4 / R6: consumer waits for its producer
        ins(4'd3, 3'd5, 3'd0, 3'd1, 1'b1, 16'd0, 16'd100, 1'b0, 2'd0, 16'd0, ta);
        @(negedge clk);
        ins(4'd4, 3'd6, 3'd5, 3'd2, 1'b0, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, tb);
        repeat (3) @(negedge clk);
        check(iss_valid == 1'b0, "R6", "send while source pending", int'(iss_valid), 0);
        expect_send(tb, 4'd4, 16'd555, 16'd2);
        bcast(ta, 16'd555);
        check(iss_valid && iss_tag == tb, "R6", "send in cycle after wakeup", int'(iss_tag), int'(tb));
        check(iss_opnd_a == 16'd555, "R4", "captured broadcast value", int'(iss_opnd_a), 555);
        @(negedge clk);

        // R5: producer result on the bus in the insert cycle
        ins(4'd5, 3'd7, 3'd6, 3'd6, 1'b1, 16'd777, 16'd777, 1'b1, tb, 16'd777, tc);
        check(iss_valid && iss_op == 4'd5 && iss_opnd_a == 16'd777, "R5", "same-cycle capture", int'(iss_opnd_a), 777);
        @(negedge clk);
        bcast(tc, 16'd999);

        // R8: two writers of r3, older result arrives first
        ins(4'd6, 3'd3, 3'd0, 3'd0, 1'b1, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, td);
        ins(4'd7, 3'd3, 3'd0, 3'd0, 1'b1, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, te);
        @(negedge clk);
        bcast(td, 16'd11);
        ins(4'd8, 3'd2, 3'd3, 3'd0, 1'b0, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, tf);
        repeat (3) @(negedge clk);
        check(iss_valid == 1'b0, "R8", "reader sent on older writer result", int'(iss_valid), 0);
        expect_send(tf, 4'd8, 16'd22, 16'd0);
        bcast(te, 16'd22);
        check(iss_valid && iss_opnd_a == 16'd22, "R8", "reader value from newest writer", int'(iss_opnd_a), 22);
        @(negedge clk);
        bcast(tf, 16'd33);

        // R2 / R7: fill every slot with a younger entry in a lower slot number
        ins(4'd9, 3'd1, 3'd0, 3'd0, 1'b1, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, tp);
        ins(4'd13, 3'd6, 3'd0, 3'd0, 1'b1, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, tq);
        ins(4'd10, 3'd2, 3'd1, 3'd0, 1'b0, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, tx);
        bcast(tq, 16'd5);
        ins(4'd11, 3'd4, 3'd1, 3'd6, 1'b0, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, ty);
        ins(4'd12, 3'd5, 3'd0, 3'd1, 1'b0, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0, tz);
        check(dec_ready == 1'b0, "R2", "dec_ready with all slots taken", int'(dec_ready), 0);
        check(ty < tx, "R7", "younger entry in lower slot", int'(ty), int'(tx));
        // dropped request aimed at r7
        dec_valid = 1'b1; dec_op = 4'd15; dec_dst = 3'd7; dec_src_a = 3'd0; dec_src_b = 3'd0;
        repeat (2) @(negedge clk);
        dec_valid = 1'b0;
        check(iss_valid == 1'b0, "R2", "send after dropped request", int'(iss_valid), 0);
        expect_send(tx, 4'd10, 16'd40, 16'd0);
        expect_send(ty, 4'd11, 16'd40, 16'd5);
        expect_send(tz, 4'd12, 16'd0, 16'd40);
        bcast(tp, 16'd40);
        check(iss_valid && iss_tag == tx, "R7", "oldest ready sent first", int'(iss_tag), int'(tx));
        repeat (3) @(negedge clk);
        bcast(tx, 16'd1);
        bcast(ty, 16'd2);
        bcast(tz, 16'd3);

        // R2: r7 must still hold the result broadcast before the dropped request
        ins(4'd14, 3'd0, 3'd7, 3'd7, 1'b1, 16'd999, 16'd999, 1'b0, 2'd0, 16'd0, tr);
        @(negedge clk);
        bcast(tr, 16'd4);
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R2", "expected sends left", sb_q.size(), 0);
        check(dec_ready == 1'b1 && dec_tag == 2'd0, "R9", "all slots released, dec_tag", int'(dec_tag), 0);
        tdum = tr;

        summary();
        $finish;
    end

endmodule